// File: doc/BRIEF.md
# Geometry coprocessor register transfer unit

This block holds the data and control register files of a fixed-point geometry coprocessor. It also holds the logic that serves the host CPU's move-to and move-from commands. Each command names a bank (data or control), a 5-bit register index and, for writes, a 32-bit value. Most registers behave as plain 32-bit storage. A few indices reshape the value as it passes:
- some 16-bit quantities widen with sign or with zeros when read;
- a colour word packs and unpacks three intermediate values with saturation;
- a three-entry screen-coordinate FIFO shifts on each push;
- one data index ignores writes;
- the projection-distance control register keeps an unsigned 16-bit meaning inside the unit but reads back sign-extended.

Reads are combinational from the stored state. Writes land at the rising clock edge, so a read and a write in the same cycle see the state from before that edge. The arithmetic engine takes the unsigned projection distance from a dedicated output.

Top module: `gte_regxfer`

## Requirements
- R1: A read of data index 1, 3, 9, 10 or 11 returns the low 16 bits of the stored word, sign-extended from bit 15 to 32 bits.
- R2: A read of data index 7, 17, 18 or 19 returns the low 16 bits of the stored word, with bits 31:16 zero.
- R3: A read of any data index not named in R1, R2, R4, R7 or R8 returns the full 32-bit word last written there.
- R4: A read of data index 15 returns the newest screen-coordinate entry, which is the word held at data index 14.
- R5: A write to data index 15 shifts the coordinate FIFO: index 12 takes the old index 13, index 13 takes the old index 14, and index 14 takes the written value.
- R6: A write to data index 28 sets index 9 to bits 4:0 of the value shifted left by 7, index 10 to bits 9:5 shifted left by 7, and index 11 to bits 14:10 shifted left by 7. All other bits of those three registers become zero.
- R7: A read of data index 28 or 29 returns bits 14:0 as three 5-bit fields, with bits 31:15 zero. Bits 4:0 come from index 9, bits 9:5 from index 10 and bits 14:10 from index 11. Each field is the low 16 bits of its source, taken as signed, arithmetically shifted right by 7, then clamped to the range 0 to 31.
- R8: A write to data index 30 changes no register, so a read of index 30 keeps returning its reset value of zero.
- R9: A read of control index 26 returns its low 16 bits sign-extended from bit 15. The output `proj_h` always carries those 16 bits unsigned.
- R10: A read of any other control index returns the full 32-bit word last written there.
- R11: A read presents the state before the clock edge. A write in the same cycle becomes visible only from the next cycle.
- R12: While reset is asserted and right after it is released, every register in both banks reads as zero and `proj_h` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write command valid this cycle |
| wr_ctrl | input | 1 | Write bank: 1 selects the control bank, 0 the data bank |
| wr_idx | input | 5 | Register index of the write |
| wr_data | input | 32 | Value to write |
| rd_ctrl | input | 1 | Read bank: 1 selects the control bank, 0 the data bank |
| rd_idx | input | 5 | Register index of the read |
| rd_data | output | 32 | Formatted read result, combinational |
| proj_h | output | 16 | Projection distance as an unsigned value |

## Verification
The assertions assume the command inputs are settled by the rising edge and that a write value is never unknown. They also assume that index 30 of the data bank is reached only through the block's own write path. The bench changes every command input only at the falling edge and samples half a cycle away from the rising edge, so both assumptions hold. It drives only known values, which it builds from loop counters and a shift-register sequence.

// File: rtl/gte_regxfer.sv
module gte_regxfer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_ctrl,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        rd_ctrl,
  input  logic [4:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic [15:0] proj_h
);

  localparam int NREG = 32;

  logic [31:0] dreg [NREG];
  logic [31:0] creg [NREG];

  function automatic logic [4:0] clamp5(input logic [15:0] v);
    logic signed [15:0] s;
    s = $signed(v) >>> 7;
    if (s < 0) return 5'd0;
    else if (s > 16'sd31) return 5'd31;
    else return s[4:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        dreg[i] <= '0;
        creg[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_ctrl) begin
        creg[wr_idx] <= wr_data;
      end else begin
        case (wr_idx)
          5'd15: begin
            dreg[12] <= dreg[13];
            dreg[13] <= dreg[14];
            dreg[14] <= wr_data;
          end
          5'd28: begin
            dreg[28] <= wr_data;
            dreg[9]  <= {20'd0, wr_data[4:0], 7'd0};
            dreg[10] <= {20'd0, wr_data[9:5], 7'd0};
            dreg[11] <= {20'd0, wr_data[14:10], 7'd0};
          end
          5'd30: ;
          default: dreg[wr_idx] <= wr_data;
        endcase
      end
    end
  end

  logic [31:0] dsel, csel;
  assign dsel = dreg[rd_idx];
  assign csel = creg[rd_idx];
  assign proj_h = creg[26][15:0];

  always_comb begin
    if (rd_ctrl) begin
      if (rd_idx == 5'd26) rd_data = {{16{csel[15]}}, csel[15:0]};
      else rd_data = csel;
    end else begin
      case (rd_idx)
        5'd1, 5'd3, 5'd9, 5'd10, 5'd11: rd_data = {{16{dsel[15]}}, dsel[15:0]};
        5'd7, 5'd17, 5'd18, 5'd19:      rd_data = {16'd0, dsel[15:0]};
        5'd15:                          rd_data = dreg[14];
        5'd28, 5'd29:                   rd_data = {17'd0, clamp5(dreg[11][15:0]),
                                                   clamp5(dreg[10][15:0]), clamp5(dreg[9][15:0])};
        default:                        rd_data = dsel;
      endcase
    end
  end

  logic rd_sext, rd_zext, rd_pack, wr_push, wr_col, wr_skip;
  assign rd_sext = !rd_ctrl && (rd_idx == 5'd1 || rd_idx == 5'd3 || rd_idx == 5'd9 ||
                                rd_idx == 5'd10 || rd_idx == 5'd11);
  assign rd_zext = !rd_ctrl && (rd_idx == 5'd7 || rd_idx == 5'd17 || rd_idx == 5'd18 ||
                                rd_idx == 5'd19);
  assign rd_pack = !rd_ctrl && (rd_idx == 5'd28 || rd_idx == 5'd29);
  assign wr_push = wr_en && !wr_ctrl && wr_idx == 5'd15;
  assign wr_col  = wr_en && !wr_ctrl && wr_idx == 5'd28;
  assign wr_skip = wr_en && !wr_ctrl && wr_idx == 5'd30;

  a_r1_sign_widen: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sext |-> rd_data[31:16] == {16{rd_data[15]}});

  a_r2_zero_widen: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zext |-> rd_data[31:16] == 16'd0);

  a_r7_pack_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pack |-> rd_data[31:15] == 17'd0);

  a_r5_fifo_shift: assert property (@(posedge clk) disable iff (!rst_n)
    wr_push |=> dreg[13] == $past(dreg[14]) && dreg[12] == $past(dreg[13])
                && dreg[14] == $past(wr_data));

  a_r6_colour_unpack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_col |=> dreg[10][11:7] == $past(wr_data[9:5]) && dreg[9][31:12] == 20'd0
               && dreg[11][6:0] == 7'd0);

  a_r8_index30_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_skip |=> $stable(dreg[30]));

  a_r9_h_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && rd_idx == 5'd26) |-> rd_data[15:0] == proj_h
                                     && rd_data[31:16] == {16{proj_h[15]}});

endmodule

// File: tb/sim_gte_regxfer.sv
module sim_gte_regxfer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_ctrl = 1'b0, rd_ctrl = 1'b0;
  logic [4:0] wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] proj_h;

  always #4 clk = ~clk;

  gte_regxfer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_ctrl(rd_ctrl), .rd_idx(rd_idx),
    .rd_data(rd_data), .proj_h(proj_h));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] md [32];
  logic [31:0] mc [32];
  logic [31:0] lfsr = 32'h1234_5678;

  function automatic logic [4:0] sat(input logic [31:0] v);
    int s;
    s = $signed(v[15:0]);
    s = s / 128 - ((s < 0 && (s % 128) != 0) ? 1 : 0);
    if (s < 0) return 5'd0;
    if (s > 31) return 5'd31;
    return 5'(s);
  endfunction

  function automatic logic [31:0] model_rd(input logic c, input logic [4:0] i);
    if (c) return (i == 26) ? {{16{mc[i][15]}}, mc[i][15:0]} : mc[i];
    case (i)
      1, 3, 9, 10, 11: return {{16{md[i][15]}}, md[i][15:0]};
      7, 17, 18, 19:   return {16'd0, md[i][15:0]};
      15:              return md[14];
      28, 29:          return {17'd0, sat(md[11]), sat(md[10]), sat(md[9])};
      default:         return md[i];
    endcase
  endfunction

  function automatic string tag_of(input logic c, input logic [4:0] i);
    if (c) return (i == 26) ? "R9" : "R10";
    case (i)
      1, 3, 9, 10, 11: return "R1";
      7, 17, 18, 19:   return "R2";
      15:              return "R4";
      28, 29:          return "R7";
      30:              return "R8";
      default:         return "R3";
    endcase
  endfunction

  task automatic model_wr(input logic c, input logic [4:0] i, input logic [31:0] v);
    if (c) mc[i] = v;
    else if (i == 15) begin md[12] = md[13]; md[13] = md[14]; md[14] = v; end
    else if (i == 28) begin
      md[28] = v;
      md[9]  = {20'd0, v[4:0], 7'd0};
      md[10] = {20'd0, v[9:5], 7'd0};
      md[11] = {20'd0, v[14:10], 7'd0};
    end
    else if (i != 30) md[i] = v;
  endtask

  task automatic step(input logic we, input logic wc, input logic [4:0] wi,
                      input logic [31:0] wd, input logic rc, input logic [4:0] ri,
                      input string tag);
    logic [31:0] exp;
    string t;
    @(negedge clk);
    wr_en = we; wr_ctrl = wc; wr_idx = wi; wr_data = wd; rd_ctrl = rc; rd_idx = ri;
    #1;
    exp = model_rd(rc, ri);
    t = (tag == "") ? tag_of(rc, ri) : tag;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s: read ctrl=%0d idx=%0d actual=%h expected=%h", t, rc, ri, rd_data, exp);
    end
    total++;
    if (proj_h !== mc[26][15:0]) begin
      bad++;
      $display("FAIL R9: proj_h actual=%h expected=%h", proj_h, mc[26][15:0]);
    end
    if (we && rst_n) model_wr(wc, wi, wd);
  endtask

  task automatic rd(input logic c, input logic [4:0] i, input string tag);
    step(1'b0, 1'b0, 5'd0, 32'd0, c, i, tag);
  endtask

  task automatic wr(input logic c, input logic [4:0] i, input logic [31:0] v);
    step(1'b1, c, i, v, c, i, "R11");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin md[i] = '0; mc[i] = '0; end
    // R12: reads under reset, writes ignored
    for (int i = 0; i < 32; i += 5) step(1'b1, 1'b0, 5'(i), 32'hFFFF_FFFF, 1'b0, 5'(i), "R12");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) begin rd(1'b0, 5'(i), "R12"); rd(1'b1, 5'(i), "R12"); end

    // R10 / R9: control bank sweep
    for (int i = 0; i < 32; i++) begin
      wr(1'b1, 5'(i), 32'h8765_8000 ^ (32'(i) * 32'h0101_0107));
      rd(1'b1, 5'(i), "");
      wr(1'b1, 5'(i), 32'h0F0F_7000 + 32'(i));
      rd(1'b1, 5'(i), "");
    end

    // R1 R2 R3 R4 R8: data bank sweep
    for (int i = 0; i < 32; i++) begin
      wr(1'b0, 5'(i), 32'hC3A5_9000 ^ (32'(i) * 32'h0011_0233));
      for (int j = 0; j < 32; j++) rd(1'b0, 5'(j), "");
    end

    // R7: saturation sweep over the low 16 bits of each source
    for (int v = 0; v < 65536; v += 97) begin
      wr(1'b0, 5'd9, 32'(v));
      wr(1'b0, 5'd10, 32'(65535 - v));
      wr(1'b0, 5'd11, 32'(v * 7));
      rd(1'b0, 5'd28, "R7");
      rd(1'b0, 5'd29, "R7");
    end

    // R6: colour word unpack
    for (int v = 0; v < 65536; v += 131) begin
      step(1'b1, 1'b0, 5'd28, 32'hABCD_0000 | 32'(v), 1'b0, 5'd9, "R6");
      rd(1'b0, 5'd9, "R6");
      rd(1'b0, 5'd10, "R6");
      rd(1'b0, 5'd11, "R6");
      rd(1'b0, 5'd28, "R6");
    end

    // R5: FIFO pushes
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, 5'd15, 32'h1000_0001 * 32'(k + 1), 1'b0, 5'd14, "R5");
      rd(1'b0, 5'd12, "R5");
      rd(1'b0, 5'd13, "R5");
      rd(1'b0, 5'd14, "R5");
      rd(1'b0, 5'd15, "R4");
    end

    // R8: writes to index 30
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 5'd30, 32'hDEAD_0000 + 32'(k), 1'b0, 5'd30, "R8");
      rd(1'b0, 5'd30, "R8");
    end

    // R11: same-cycle write and read of the same register
    for (int i = 0; i < 32; i += 3) begin
      wr(1'b1, 5'(i), 32'h5555_0000 + 32'(i));
      rd(1'b1, 5'(i), "R11");
      wr(1'b0, 5'(i), 32'hAAAA_8000 + 32'(i));
      rd(1'b0, 5'(i), "R11");
    end

    // mixed traffic
    for (int k = 0; k < 4000; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[0], lfsr[1], lfsr[6:2], {lfsr[15:0], lfsr[31:16]} ^ 32'(k),
           lfsr[7], lfsr[12:8], "");
    end

    finish_run();
  end
endmodule